// File: doc/BRIEF.md
# ATR Early Answer Detector

During card activation the interface raises and lowers the card reset line. A card must not start its answer too early in either reset phase. This block watches the card I/O line and the reset line level, counts card clock pulses in each reset phase, and raises a sticky flag when the card's first start bit comes too early.

A phase starts when the block comes out of reset, which begins a reset-low phase, and again each time the reset line level changes. The phase count restarts on each of these events. In a reset-low phase, I/O activity during an initial blanking interval is ignored. After that interval, a first start bit is early if it comes before the window limit. In a reset-high phase, any first start bit before the window limit is early. Only the first counted start bit of a phase is judged. Software clears the flag with a one-cycle clear strobe. A reset-line toggle also clears it.

Top module: `atr_early_detect`

## Requirements
- R1: After `rst_n` is released, `early_flag` is 0. A reset-low phase begins with its phase count at 0. The phase count is the number of rising `clk` edges since the phase began.
- R2: A start bit is a high-to-low change of `card_io` after a two-stage synchronizer. If `card_io` is low at the negative edge that follows phase count C, the start bit is judged against phase count C+2.
- R3: In a reset-low phase, a start bit judged at a count below BLANK (200) is ignored. It does not set the flag, and it does not use up the phase's single judged start bit.
- R4: In a reset-low phase, a first counted start bit judged at a count from 200 to 367 sets `early_flag`. One judged at 368 or later does not set it.
- R5: In a reset-high phase, a first start bit judged at a count below WINDOW (368) sets `early_flag`. One judged at 368 or later does not set it.
- R6: A change of `card_rst` restarts the phase. The count goes back to 0, the phase's judged start bit is forgotten, and `early_flag` is cleared.
- R7: The phase count saturates at 368. A start bit after a very long phase never sets the flag.
- R8: Only the first counted start bit of a phase is judged. Later falling edges in the same phase never set the flag.
- R9: A one-cycle high on `rd_clr` clears `early_flag` on the next edge. If a start bit sets the flag in that same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Card clock; each rising edge is one counted pulse |
| rst_n | input | 1 | Asynchronous active-low block reset |
| card_rst | input | 1 | Card reset line level, synchronous to `clk` |
| card_io | input | 1 | Card I/O line, asynchronous, idle high |
| rd_clr | input | 1 | Status read strobe; clears the flag |
| early_flag | output | 1 | Sticky early-answer status |

## Verification
The assertions assume that `card_rst` is already synchronous to `clk` and is held low while `rst_n` is asserted. They also assume that `card_io` idles high, so the first phase does not begin with a false falling edge. The stimulus changes `card_rst`, `card_io` and `rd_clr` only on falling clock edges. It keeps `card_io` high through every reset and every phase change. Each start bit is a low pulse of at least two clocks, so the synchronizer always sees it.

// File: rtl/atr_early_detect.sv
module atr_early_detect #(
  parameter int BLANK  = 200,
  parameter int WINDOW = 368
) (
  input  logic clk,
  input  logic rst_n,
  input  logic card_rst,
  input  logic card_io,
  input  logic rd_clr,
  output logic early_flag
);
  localparam int CW = $clog2(WINDOW + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(WINDOW);
  localparam logic [CW-1:0] CNT_BLK = CW'(BLANK);

  logic [CW-1:0] cnt;
  logic          rst_q, seen;
  logic          io_s1, io_s2, io_s3;
  logic          toggle, fall, in_win, past_blank, counted, hit;

  assign toggle     = card_rst ^ rst_q;
  assign fall       = io_s3 & ~io_s2;
  assign in_win     = cnt < CNT_MAX;
  assign past_blank = rst_q | (cnt >= CNT_BLK);
  assign counted    = fall & ~seen & ~toggle & past_blank;
  assign hit        = counted & in_win;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {io_s1, io_s2, io_s3} <= 3'b111;
    else        {io_s1, io_s2, io_s3} <= {card_io, io_s1, io_s2};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rst_q <= 1'b0;
      cnt   <= '0;
      seen  <= 1'b0;
    end else begin
      rst_q <= card_rst;
      if (toggle) begin
        cnt  <= '0;
        seen <= 1'b0;
      end else begin
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        if (counted)        seen <= 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      early_flag <= 1'b0;
    else if (toggle) early_flag <= 1'b0;
    else if (hit)    early_flag <= 1'b1;
    else if (rd_clr) early_flag <= 1'b0;

  AST_TOGGLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    toggle |=> (!early_flag && cnt == '0)); // R6
  AST_BLANK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && !rst_q && cnt < CNT_BLK && !toggle) |=> (!$rose(early_flag) && seen == $past(seen))); // R3
  AST_SET_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(early_flag) |-> ($past(cnt) < CNT_MAX)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && !toggle) |=> cnt == CNT_MAX); // R7
  AST_ONE_PER_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !toggle) |=> !$rose(early_flag)); // R8
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !hit) |=> !early_flag); // R9
endmodule

// File: tb/atr_early_detect_tb.sv
module atr_early_detect_tb;
  logic clk = 1'b0, rst_n = 1'b0, card_rst = 1'b0, card_io = 1'b1, rd_clr = 1'b0;
  logic early_flag;
  int   n_chk = 0, n_bad = 0;

  atr_early_detect u_dut (.clk(clk), .rst_n(rst_n), .card_rst(card_rst),
                          .card_io(card_io), .rd_clr(rd_clr), .early_flag(early_flag));

  always #10 clk = ~clk;

  // {high_phase, drop count D, expected}; judged count is D+2 (R2)
  localparam logic [11:0] VEC [12] = '{
    {1'b0, 10'd150, 1'b0}, {1'b0, 10'd250, 1'b1}, {1'b0, 10'd400, 1'b0},
    {1'b0, 10'd197, 1'b0}, {1'b0, 10'd198, 1'b1}, {1'b0, 10'd365, 1'b1},
    {1'b0, 10'd366, 1'b0}, {1'b1, 10'd150, 1'b1}, {1'b1, 10'd250, 1'b1},
    {1'b1, 10'd400, 1'b0}, {1'b1, 10'd365, 1'b1}, {1'b1, 10'd366, 1'b0}};

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: early_flag=%0b expected %0b", req, act, exp);
    end
  endtask

  task automatic start_low();
    @(negedge clk);
    rst_n = 1'b0; card_rst = 1'b0; card_io = 1'b1; rd_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic go_high();
    repeat (400) @(posedge clk);
    @(negedge clk) card_rst = 1'b1;
    @(posedge clk);
  endtask

  task automatic start_bit();
    @(negedge clk) card_io = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk) card_io = 1'b1;
  endtask

  task automatic settle();
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    start_low();
    @(negedge clk);
    check("R1 reset state", early_flag, 1'b0);

    foreach (VEC[i]) begin
      start_low();
      if (VEC[i][11]) go_high();
      repeat (int'(VEC[i][10:1])) @(posedge clk);
      start_bit();
      settle();
      check(VEC[i][11] ? "R5 high-phase window" : "R4 low-phase window/R3 blank",
            early_flag, VEC[i][0]);
    end

    // R3: blanked edge does not use up the phase
    start_low();
    repeat (150) @(posedge clk);
    start_bit();
    repeat (98) @(posedge clk);
    start_bit();
    settle();
    check("R3 blanked edge then window edge", early_flag, 1'b1);

    // R9: read strobe clears
    @(negedge clk) rd_clr = 1'b1;
    @(negedge clk) rd_clr = 1'b0;
    check("R9 read clears flag", early_flag, 1'b0);

    // R8: only first start bit judged
    start_low();
    go_high();
    repeat (100) @(posedge clk);
    start_bit();
    settle();
    check("R8 first high-phase edge sets", early_flag, 1'b1);
    @(negedge clk) rd_clr = 1'b1;
    @(negedge clk) rd_clr = 1'b0;
    repeat (50) @(posedge clk);
    start_bit();
    settle();
    check("R8 second edge ignored", early_flag, 1'b0);

    // R6: toggle clears the flag and restarts
    start_low();
    repeat (250) @(posedge clk);
    start_bit();
    settle();
    check("R6 low answer before toggle", early_flag, 1'b1);
    @(negedge clk) card_rst = 1'b1;
    @(negedge clk);
    check("R6 toggle clears flag", early_flag, 1'b0);
    repeat (20) @(posedge clk);
    start_bit();
    settle();
    check("R6 restarted high phase detects", early_flag, 1'b1);

    // R7: no wrap in a long phase
    start_low();
    repeat (780) @(posedge clk);
    start_bit();
    settle();
    check("R7 long low phase no set", early_flag, 1'b0);
    start_low();
    go_high();
    repeat (900) @(posedge clk);
    start_bit();
    settle();
    check("R7 long high phase no set", early_flag, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule